// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block sits in front of the two operand inputs of an ALU. The value read from the register file or from memory is the usual source for each operand. The ALU result, however, takes several cycles to be written back. A consumer that names that result's register straight after it was computed would otherwise read a stale value. The block avoids this by keeping a registered copy of the most recent ALU result, together with its destination register tag and a valid flag. For each operand it compares the source tag with that stored tag, and when they match it passes the stored result on in place of the fetched value.

Each operand path is a two-way selection followed by an output register, and both paths can take the bypass value in the same cycle. An operand presented in cycle t shows up at the outputs after the clock edge that ends cycle t, with a flag that says which source was taken. A result presented in cycle t can be bypassed to operands presented from cycle t+1 on. The stored copy stops matching once the result has been written back. It is also replaced as soon as the ALU produces a newer result.

Top module: `alu_bypass_steer`

## Requirements
- R1: While `rst` is high at a clock edge, both operand outputs become zero, both select flags become 0 and the stored result is marked invalid, so that no operand presented after reset is bypassed until a new result is loaded.
- R2: An operand that does not match is passed through: the output after the next edge equals the fetched value and its select flag is 0.
- R3: An operand matches when the stored result is valid, the operand is not a memory operand, and its source tag is nonzero and equal to the stored destination tag. The output after the next edge then equals the stored result value and the select flag is 1 (flag value 1 means bypass, 0 means fetched).
- R4: Register tag 0 never matches, even when the stored result carries destination tag 0.
- R5: An operand with its memory flag set never matches, whatever its tag.
- R6: A writeback indication (`wb_done` high) without a new result in the same cycle marks the stored result invalid from the next cycle on.
- R7: A new result (`res_valid` high) is stored with its data and tag and marked valid, and this takes priority over a writeback indication in the same cycle.
- R8: Both operands can select the bypass value in the same cycle.
- R9: Only the latest result is held: after a newer result is loaded, an operand naming the older result's tag (when it differs) receives its fetched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | ALU produced a result this cycle |
| res_data | input | DATA_W | ALU result value |
| res_tag | input | TAG_W | Destination register of the ALU result |
| wb_done | input | 1 | Stored result has been written back |
| opa_data | input | DATA_W | Fetched value for operand A |
| opa_tag | input | TAG_W | Source register of operand A |
| opa_mem | input | 1 | Operand A comes from memory |
| opb_data | input | DATA_W | Fetched value for operand B |
| opb_tag | input | TAG_W | Source register of operand B |
| opb_mem | input | 1 | Operand B comes from memory |
| alu_a | output | DATA_W | Selected operand A, registered |
| alu_b | output | DATA_W | Selected operand B, registered |
| a_bypassed | output | 1 | 1 when operand A took the bypass value |
| b_bypassed | output | 1 | 1 when operand B took the bypass value |

## Verification
A wrong stored valid bit, tag or value in the bypass register shows up on the cycle after the first operand that names that tag. It appears as a wrong operand value together with a wrong select flag. The stimulus therefore probes the stored state with an operand after every change to it: load, clear, replacement, and a load and clear in the same cycle. A stale or missing reset shows up on the first operand presented after reset. Tag-zero and memory-operand cases are paired with a stored result that would otherwise match, so a missing qualifier gives a wrong flag after one edge.

// File: rtl/byp_pkg.sv
package byp_pkg;
  localparam int NUM_OPERANDS = 2;

  typedef enum logic {
    SRC_FETCHED = 1'b0,
    SRC_BYPASS  = 1'b1
  } src_sel_e;
endpackage

// File: rtl/byp_entry_reg.sv
module byp_entry_reg #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [TAG_W-1:0]  load_tag_i,
  input  logic              clear_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic [TAG_W-1:0]  tag_q;

  // A new result wins over a writeback clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      tag_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= load_data_i;
      tag_q   <= load_tag_i;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign tag_o   = tag_q;

  assert_clear_on_wb_R6: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !load_i) |=> !valid_q);

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (valid_q && data_q == $past(load_data_i) && tag_q == $past(load_tag_i)));
endmodule

// File: rtl/byp_tag_match.sv
module byp_tag_match #(
  parameter int TAG_W = 5
) (
  input  logic             entry_valid_i,
  input  logic [TAG_W-1:0] entry_tag_i,
  input  logic [TAG_W-1:0] src_tag_i,
  input  logic             src_mem_i,
  output byp_pkg::src_sel_e sel_o
);
  import byp_pkg::*;

  logic tag_nonzero;
  logic tag_equal;

  assign tag_nonzero = |src_tag_i;
  assign tag_equal   = (src_tag_i == entry_tag_i);

  always_comb begin
    sel_o = SRC_FETCHED;
    if (entry_valid_i && !src_mem_i && tag_nonzero && tag_equal)
      sel_o = SRC_BYPASS;
  end
endmodule

// File: rtl/byp_operand_mux.sv
module byp_operand_mux #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  byp_pkg::src_sel_e sel_i,
  input  logic [DATA_W-1:0] fetch_i,
  input  logic [DATA_W-1:0] bypass_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bypassed_o
);
  import byp_pkg::*;

  logic [DATA_W-1:0] data_q;
  logic              byp_q;
  logic              rst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      byp_q  <= 1'b0;
    end else begin
      data_q <= (sel_i == SRC_BYPASS) ? bypass_i : fetch_i;
      byp_q  <= (sel_i == SRC_BYPASS);
    end
  end

  always_ff @(posedge clk) rst_q <= rst;

  assign data_o     = data_q;
  assign bypassed_o = byp_q;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      assert_reset_clear_R1: assert (data_q == '0 && !byp_q);
    end
  end

  assert_pass_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_i == SRC_FETCHED) |=> (!byp_q && data_q == $past(fetch_i)));

  assert_take_bypass_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_i == SRC_BYPASS) |=> (byp_q && data_q == $past(bypass_i)));
endmodule

// File: rtl/alu_bypass_steer.sv
module alu_bypass_steer #(
  parameter int  DATA_W   = 32,
  parameter int  NUM_REGS = 32,
  localparam int TAG_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic              wb_done,
  input  logic [DATA_W-1:0] opa_data,
  input  logic [TAG_W-1:0]  opa_tag,
  input  logic              opa_mem,
  input  logic [DATA_W-1:0] opb_data,
  input  logic [TAG_W-1:0]  opb_tag,
  input  logic              opb_mem,
  output logic [DATA_W-1:0] alu_a,
  output logic [DATA_W-1:0] alu_b,
  output logic              a_bypassed,
  output logic              b_bypassed
);
  import byp_pkg::*;

  localparam int NOPS = NUM_OPERANDS;

  logic              ent_valid;
  logic [DATA_W-1:0] ent_data;
  logic [TAG_W-1:0]  ent_tag;

  logic [DATA_W-1:0] op_data [NOPS];
  logic [TAG_W-1:0]  op_tag  [NOPS];
  logic              op_mem  [NOPS];
  src_sel_e          op_sel  [NOPS];
  logic [DATA_W-1:0] out_data[NOPS];
  logic              out_byp [NOPS];

  assign op_data[0] = opa_data;
  assign op_tag[0]  = opa_tag;
  assign op_mem[0]  = opa_mem;
  assign op_data[1] = opb_data;
  assign op_tag[1]  = opb_tag;
  assign op_mem[1]  = opb_mem;

  byp_entry_reg #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
    .clk         (clk),
    .rst         (rst),
    .load_i      (res_valid),
    .load_data_i (res_data),
    .load_tag_i  (res_tag),
    .clear_i     (wb_done),
    .valid_o     (ent_valid),
    .data_o      (ent_data),
    .tag_o       (ent_tag)
  );

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    byp_tag_match #(.TAG_W(TAG_W)) u_match (
      .entry_valid_i (ent_valid),
      .entry_tag_i   (ent_tag),
      .src_tag_i     (op_tag[k]),
      .src_mem_i     (op_mem[k]),
      .sel_o         (op_sel[k])
    );

    byp_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .clk        (clk),
      .rst        (rst),
      .sel_i      (op_sel[k]),
      .fetch_i    (op_data[k]),
      .bypass_i   (ent_data),
      .data_o     (out_data[k]),
      .bypassed_o (out_byp[k])
    );
  end

  assign alu_a      = out_data[0];
  assign alu_b      = out_data[1];
  assign a_bypassed = out_byp[0];
  assign b_bypassed = out_byp[1];

  assert_zero_tag_a_R4: assert property (@(posedge clk) disable iff (rst)
    (opa_tag == '0) |=> !a_bypassed);
  assert_zero_tag_b_R4: assert property (@(posedge clk) disable iff (rst)
    (opb_tag == '0) |=> !b_bypassed);
  assert_mem_a_R5: assert property (@(posedge clk) disable iff (rst)
    opa_mem |=> !a_bypassed);
  assert_mem_b_R5: assert property (@(posedge clk) disable iff (rst)
    opb_mem |=> !b_bypassed);
  assert_no_stale_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_done && !res_valid) |=> ##1 (!a_bypassed && !b_bypassed));
endmodule

// File: tb/alu_bypass_steer_test.sv
`timescale 1ns/1ps
module alu_bypass_steer_test;
  localparam int DW = 32;
  localparam int TW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          res_valid, wb_done;
  logic [DW-1:0] res_data, opa_data, opb_data;
  logic [TW-1:0] res_tag, opa_tag, opb_tag;
  logic          opa_mem, opb_mem;
  logic [DW-1:0] alu_a, alu_b;
  logic          a_bypassed, b_bypassed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_bypass_steer #(.DATA_W(DW), .NUM_REGS(32)) uut (
    .clk(clk), .rst(rst),
    .res_valid(res_valid), .res_data(res_data), .res_tag(res_tag),
    .wb_done(wb_done),
    .opa_data(opa_data), .opa_tag(opa_tag), .opa_mem(opa_mem),
    .opb_data(opb_data), .opb_tag(opb_tag), .opb_mem(opb_mem),
    .alu_a(alu_a), .alu_b(alu_b),
    .a_bypassed(a_bypassed), .b_bypassed(b_bypassed)
  );

  typedef struct packed {
    logic          rv;
    logic [TW-1:0] rt;
    logic [DW-1:0] rd;
    logic          wb;
    logic [TW-1:0] at;
    logic          am;
    logic [DW-1:0] ad;
    logic [TW-1:0] bt;
    logic          bm;
    logic [DW-1:0] bd;
    logic [DW-1:0] ea;
    logic          eab;
    logic [DW-1:0] eb;
    logic          ebb;
  } vec_t;

  localparam int NV = 10;
  // rv rt rd wb | at am ad | bt bm bd | exp a, a flag, exp b, b flag
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd3, 32'h1111, 1'b0, 5'd3, 1'b0, 32'hA0, 5'd0, 1'b0, 32'hB0, 32'hA0, 1'b0, 32'hB0, 1'b0},
    '{1'b0, 5'd0, 32'h0,    1'b0, 5'd3, 1'b0, 32'hA1, 5'd3, 1'b0, 32'hB1, 32'h1111, 1'b1, 32'h1111, 1'b1},
    '{1'b0, 5'd0, 32'h0,    1'b0, 5'd0, 1'b0, 32'hA2, 5'd3, 1'b1, 32'hB2, 32'hA2, 1'b0, 32'hB2, 1'b0},
    '{1'b0, 5'd0, 32'h0,    1'b1, 5'd4, 1'b0, 32'hA3, 5'd3, 1'b0, 32'hB3, 32'hA3, 1'b0, 32'h1111, 1'b1},
    '{1'b1, 5'd7, 32'h2222, 1'b1, 5'd3, 1'b0, 32'hA4, 5'd3, 1'b0, 32'hB4, 32'hA4, 1'b0, 32'hB4, 1'b0},
    '{1'b1, 5'd9, 32'h3333, 1'b0, 5'd7, 1'b0, 32'hA5, 5'd7, 1'b1, 32'hB5, 32'h2222, 1'b1, 32'hB5, 1'b0},
    '{1'b1, 5'd9, 32'h4444, 1'b0, 5'd7, 1'b0, 32'hA6, 5'd9, 1'b0, 32'hB6, 32'hA6, 1'b0, 32'h3333, 1'b1},
    '{1'b0, 5'd0, 32'h0,    1'b0, 5'd9, 1'b0, 32'hA7, 5'd9, 1'b0, 32'hB7, 32'h4444, 1'b1, 32'h4444, 1'b1},
    '{1'b1, 5'd0, 32'h5555, 1'b0, 5'd0, 1'b0, 32'hA8, 5'd9, 1'b0, 32'hB8, 32'hA8, 1'b0, 32'h4444, 1'b1},
    '{1'b0, 5'd0, 32'h0,    1'b0, 5'd0, 1'b0, 32'hA9, 5'd9, 1'b0, 32'hB9, 32'hA9, 1'b0, 32'hB9, 1'b0}
  };

  // Requirement tag of each vector, for the messages.
  localparam string VREQ [NV] = '{"R2", "R3 R8", "R4 R5", "R6 R2", "R6 R7",
                                  "R7 R5", "R9", "R8", "R4", "R4 R9"};

  task automatic chk_data(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    res_valid = 1'b0; res_data = '0; res_tag = '0; wb_done = 1'b0;
    opa_data = '0; opa_tag = '0; opa_mem = 1'b0;
    opb_data = '0; opb_tag = '0; opb_mem = 1'b0;
  endtask

  task automatic apply(vec_t v);
    res_valid = v.rv; res_tag = v.rt; res_data = v.rd; wb_done = v.wb;
    opa_tag = v.at; opa_mem = v.am; opa_data = v.ad;
    opb_tag = v.bt; opb_mem = v.bm; opb_data = v.bd;
    @(posedge clk);
    #1;
  endtask

  initial begin
    drive_idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs cleared during reset
    chk_data("R1", alu_a, '0);
    chk_data("R1", alu_b, '0);
    chk_bit("R1", a_bypassed, 1'b0);
    chk_bit("R1", b_bypassed, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      chk_data(VREQ[i], alu_a, VEC[i].ea);
      chk_bit(VREQ[i], a_bypassed, VEC[i].eab);
      chk_data(VREQ[i], alu_b, VEC[i].eb);
      chk_bit(VREQ[i], b_bypassed, VEC[i].ebb);
    end

    // Directed R1: reset with a valid stored result, then probe its tag.
    apply('{1'b1, 5'd12, 32'hC0DE, 1'b0, 5'd1, 1'b0, 32'h1, 5'd1, 1'b0, 32'h2,
            32'h0, 1'b0, 32'h0, 1'b0});
    drive_idle();
    opa_tag = 5'd12; opa_data = 32'hD1;
    opb_tag = 5'd12; opb_data = 32'hD2;
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk_data("R1", alu_a, '0);
    chk_bit("R1", a_bypassed, 1'b0);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk_data("R1", alu_a, 32'hD1);
    chk_bit("R1", a_bypassed, 1'b0);
    chk_data("R1", alu_b, 32'hD2);
    chk_bit("R1", b_bypassed, 1'b0);

    // Directed R3: highest tag and an all-ones value.
    res_valid = 1'b1; res_tag = 5'd31; res_data = 32'hFFFF_FFFF;
    @(posedge clk);
    #1;
    res_valid = 1'b0;
    opa_tag = 5'd31; opa_data = 32'h0;
    @(posedge clk);
    #1;
    chk_data("R3", alu_a, 32'hFFFF_FFFF);
    chk_bit("R3", a_bypassed, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog actual=timeout expected=completion");
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule